// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is a controller that lets software run an I2C bus as a master, one byte at a time. Software reaches it through a small memory-mapped register port. It writes triggers that create start, repeated-start and stop conditions. It writes bytes that go out on the bus, and it releases the bus to clock bytes in. The block drives SCL and SDA as open-drain lines: a set output enable pulls the line low. It samples SDA to read bytes and acknowledges.

After each byte the controller parks the bus with SCL held low and sends a one-cycle interrupt pulse. Software chooses where a received byte stops: after the eighth clock or after the ninth. Stopping after the eighth clock lets software look at the byte before it sets the acknowledge level, so the last byte of a read can be NACKed. Address bytes are ordinary data writes. The SCL low and high durations are programmable in clock cycles.

Register offsets (byte addresses): data 0x00, control 0x08, trigger 0x0C, status 0x10, SCL low width 0x24, SCL high width 0x28. Control fields: bit 7 enable, bit 1 wait point (1 = after the ninth clock, 0 = after the eighth), bit 0 drive ACK on received bytes. Trigger fields, each acting when written as one: bit 2 release wait, bit 1 start, bit 0 stop. Status fields: bit 8 acknowledge received, bit 6 bus busy, bit 4 stop seen.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, and whenever the controller is idle, both output enables are low, irq is low and the status register reads zero.
- R2: The width registers at 0x24 and 0x28 set how many clock cycles SCL stays low and high for each data bit. They read back as written.
- R3: While control bit 7 is 0, trigger and data writes have no effect on the bus or on the status. Clearing bit 7 returns the controller to idle, releases both lines and clears the busy (bit 6) and stop-seen (bit 4) status flags.
- R4: Writing trigger bit 1 from idle pulls SDA low while SCL is high, and then holds SCL low. It sets busy and clears stop-seen.
- R5: A data-register write while the bus is held sends the byte MSB first on eight SCL pulses. A ninth pulse follows with SDA released.
- R6: After a transmitted byte, the interrupt is raised after the ninth clock. Status bit 8 is then 1 when the receiver pulled SDA low on that clock and 0 otherwise.
- R7: At every wait point SCL stays low and no further pulses occur until software writes a trigger or data.
- R8: With control bit 1 = 0, a release trigger clocks in eight bits and stops after the eighth clock. The data register then reads the received byte MSB first. The next release runs the ninth clock and then the next byte.
- R9: On the ninth clock of a received byte, SDA is pulled low when control bit 0 is 1 (ACK) and released when it is 0 (NACK).
- R10: With control bit 1 = 1, a pending receive continues through the ninth clock before it waits.
- R11: Trigger bit 0 while the bus is held produces a stop condition, with SDA rising while SCL is high. It then sets stop-seen and clears busy.
- R12: Trigger bit 1 while the bus is held produces a repeated start without a stop condition in between.
- R13: irq is a single-cycle pulse, one per wait point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | One-cycle pulse at each wait point |

## Verification
A behavioural bus model decodes start, stop, bits and acknowledges from the resolved lines on every clock. It also acts as a slave that picks its direction from the address LSB. Transmit runs with the slave acknowledging and with the slave refusing, which separates a correct ACK flag from a stuck one. Receive runs with eighth-clock waits, ninth-clock waits, ACK and NACK. Counting SCL pulses per release shows where each wait point falls. Triggers are also tried with the controller disabled, together with a repeated start and a mid-transfer disable.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_DATA = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTL0 = 6'h08;
  localparam logic [ADDR_W-1:0] A_TRIG = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h10;
  localparam logic [ADDR_W-1:0] A_LOW  = 6'h24;
  localparam logic [ADDR_W-1:0] A_HIGH = 6'h28;

  // control bits
  localparam int C_EN    = 7;
  localparam int C_WAIT9 = 1;
  localparam int C_ACKEN = 0;
  // trigger bits
  localparam int T_REL = 2;
  localparam int T_STA = 1;
  localparam int T_STO = 0;
  // status bits
  localparam int S_ACK  = 8;
  localparam int S_BUSY = 6;
  localparam int S_STOP = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_LO,
    ST_HI,
    ST_RS_LO,
    ST_RS_HI,
    ST_STOP_LO,
    ST_STOP_HI
  } eng_state_t;
endpackage

// File: rtl/i2c_bm_phase.sv
module i2c_bm_phase #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] width,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (width == '0) ? '0 : width - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            CW       = 10,
  parameter logic [CW-1:0] LOW_RST  = 8,
  parameter logic [CW-1:0] HIGH_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [7:0]        rx_byte,
  input  logic              ack_seen,
  input  logic              busy,
  input  logic              stop_seen,
  input  logic              take_start,
  input  logic              take_stop,
  input  logic              take_tx,
  input  logic              take_rel,
  output logic              enable,
  output logic              ack_en,
  output logic              wait9,
  output logic [CW-1:0]     low_w,
  output logic [CW-1:0]     high_w,
  output logic [7:0]        tx_byte,
  output logic              pend_start,
  output logic              pend_stop,
  output logic              pend_tx,
  output logic              pend_rel
);
  logic wr, rd, trig_wr, data_wr;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign trig_wr = wr && (bus_addr == A_TRIG);
  assign data_wr = wr && (bus_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= 1'b0;
      ack_en  <= 1'b0;
      wait9   <= 1'b0;
      low_w   <= LOW_RST;
      high_w  <= HIGH_RST;
      tx_byte <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_CTL0: begin
          enable <= bus_wdata[C_EN];
          wait9  <= bus_wdata[C_WAIT9];
          ack_en <= bus_wdata[C_ACKEN];
        end
        A_LOW:   low_w   <= bus_wdata[CW-1:0];
        A_HIGH:  high_w  <= bus_wdata[CW-1:0];
        A_DATA:  tx_byte <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  // requests wait here until the engine reaches a state that accepts them
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_start <= 1'b0;
      pend_stop  <= 1'b0;
      pend_tx    <= 1'b0;
      pend_rel   <= 1'b0;
    end else begin
      pend_start <= enable & ((pend_start & ~take_start) | (trig_wr & bus_wdata[T_STA]));
      pend_stop  <= enable & ((pend_stop  & ~take_stop)  | (trig_wr & bus_wdata[T_STO]));
      pend_rel   <= enable & ((pend_rel   & ~take_rel)   | (trig_wr & bus_wdata[T_REL]));
      pend_tx    <= enable & ((pend_tx    & ~take_tx)    | data_wr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_DATA: bus_rdata[7:0] <= rx_byte;
        A_CTL0: begin
          bus_rdata[C_EN]    <= enable;
          bus_rdata[C_WAIT9] <= wait9;
          bus_rdata[C_ACKEN] <= ack_en;
        end
        A_STAT: begin
          bus_rdata[S_ACK]  <= ack_seen;
          bus_rdata[S_BUSY] <= busy;
          bus_rdata[S_STOP] <= stop_seen;
        end
        A_LOW:   bus_rdata[CW-1:0] <= low_w;
        A_HIGH:  bus_rdata[CW-1:0] <= high_w;
        default: ;
      endcase
    end
  end

  p_no_pend_off_r3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pend_start && !pend_stop && !pend_tx && !pend_rel);
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          ack_en,
  input  logic          wait9,
  input  logic [CW-1:0] low_w,
  input  logic [CW-1:0] high_w,
  input  logic [7:0]    tx_byte,
  input  logic          pend_start,
  input  logic          pend_stop,
  input  logic          pend_tx,
  input  logic          pend_rel,
  input  logic          sda_in,
  output logic          take_start,
  output logic          take_stop,
  output logic          take_tx,
  output logic          take_rel,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq,
  output logic [7:0]    rx_byte,
  output logic          ack_seen,
  output logic          busy,
  output logic          stop_seen
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_BIT  = 4'd8;

  eng_state_t    state, state_n;
  logic [3:0]    idx;
  logic          tx_mode, mid_byte;
  logic [7:0]    shreg;
  logic          load, done, end_wait, bit_drive, scl_d, sda_d;
  logic [CW-1:0] ld_w;

  i2c_bm_phase #(.CW(CW)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .width(ld_w),
    .done (done)
  );

  // receive waits at the eighth clock unless the ninth is selected
  assign end_wait = ((idx == ACK_BIT) && (tx_mode || wait9)) ||
                    ((idx == LAST_BIT) && !tx_mode && !wait9);

  always_comb begin
    if (idx == ACK_BIT) bit_drive = tx_mode ? 1'b0 : ack_en;
    else                bit_drive = tx_mode ? ~shreg[7] : 1'b0;
  end

  always_comb begin
    state_n    = state;
    load       = 1'b0;
    ld_w       = low_w;
    take_start = 1'b0;
    take_stop  = 1'b0;
    take_tx    = 1'b0;
    take_rel   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (pend_start) begin
          take_start = 1'b1;
          state_n    = ST_START;
          load       = 1'b1;
          ld_w       = high_w;
        end else begin
          take_stop = pend_stop;
          take_tx   = pend_tx;
          take_rel  = pend_rel;
        end
      end
      ST_START:   if (done) state_n = ST_HOLD;
      ST_HOLD: begin
        load = pend_start | pend_stop | pend_tx | pend_rel;
        if (pend_start) begin
          take_start = 1'b1;
          state_n    = ST_RS_LO;
        end else if (pend_stop) begin
          take_stop = 1'b1;
          state_n   = ST_STOP_LO;
        end else if (pend_tx) begin
          take_tx = 1'b1;
          state_n = ST_LO;
        end else if (pend_rel) begin
          take_rel = 1'b1;
          state_n  = ST_LO;
        end
      end
      ST_LO: if (done) begin
        state_n = ST_HI;
        load    = 1'b1;
        ld_w    = high_w;
      end
      ST_HI: if (done) begin
        if (end_wait) begin
          state_n = ST_HOLD;
        end else begin
          state_n = ST_LO;
          load    = 1'b1;
        end
      end
      ST_RS_LO: if (done) begin
        state_n = ST_RS_HI;
        load    = 1'b1;
        ld_w    = high_w;
      end
      ST_RS_HI: if (done) begin
        state_n = ST_START;
        load    = 1'b1;
        ld_w    = high_w;
      end
      ST_STOP_LO: if (done) begin
        state_n = ST_STOP_HI;
        load    = 1'b1;
        ld_w    = high_w;
      end
      ST_STOP_HI: if (done) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
    if (!enable) begin
      state_n = ST_IDLE;
      load    = 1'b0;
    end
  end

  always_comb begin
    case (state)
      ST_START:   begin scl_d = 1'b0; sda_d = 1'b1;      end
      ST_HOLD:    begin scl_d = 1'b1; sda_d = 1'b0;      end
      ST_LO:      begin scl_d = 1'b1; sda_d = bit_drive; end
      ST_HI:      begin scl_d = 1'b0; sda_d = bit_drive; end
      ST_RS_LO:   begin scl_d = 1'b1; sda_d = 1'b0;      end
      ST_STOP_LO: begin scl_d = 1'b1; sda_d = 1'b1;      end
      ST_STOP_HI: begin scl_d = 1'b0; sda_d = 1'b1;      end
      default:    begin scl_d = 1'b0; sda_d = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      tx_mode   <= 1'b0;
      mid_byte  <= 1'b0;
      shreg     <= '0;
      ack_seen  <= 1'b0;
      busy      <= 1'b0;
      stop_seen <= 1'b0;
      irq       <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      state  <= state_n;
      irq    <= 1'b0;
      scl_oe <= scl_d;
      sda_oe <= sda_d;
      if (!enable) begin
        busy      <= 1'b0;
        stop_seen <= 1'b0;
        mid_byte  <= 1'b0;
        idx       <= '0;
      end else begin
        case (state)
          ST_IDLE: if (pend_start) begin
            busy      <= 1'b1;
            stop_seen <= 1'b0;
          end
          ST_HOLD: begin
            if (pend_start) begin
              stop_seen <= 1'b0;
            end else if (pend_stop) begin
              mid_byte <= 1'b0;
            end else if (pend_tx) begin
              tx_mode  <= 1'b1;
              idx      <= '0;
              shreg    <= tx_byte;
              mid_byte <= 1'b0;
            end else if (pend_rel) begin
              tx_mode  <= 1'b0;
              idx      <= mid_byte ? ACK_BIT : 4'd0;
              mid_byte <= 1'b0;
            end
          end
          ST_HI: if (done) begin
            if (idx != ACK_BIT) shreg <= {shreg[6:0], sda_in};
            if ((idx == ACK_BIT) && tx_mode) ack_seen <= ~sda_in;
            if (end_wait) begin
              irq      <= 1'b1;
              mid_byte <= (idx == LAST_BIT);
            end else begin
              idx <= (idx == ACK_BIT) ? 4'd0 : idx + 1'b1;
            end
          end
          ST_STOP_HI: if (done) begin
            busy      <= 1'b0;
            stop_seen <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_byte = shreg;

  p_irq_one_r13: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);

  p_off_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state == ST_IDLE) && !busy && !stop_seen);

  p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) && ($past(state) == ST_HOLD) |-> scl_oe);

  p_stop_not_busy_r11: assert property (@(posedge clk) disable iff (rst)
    stop_seen |-> !busy);

  p_idle_free_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && ($past(state) == ST_IDLE) |-> !scl_oe && !sda_oe);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int            DATA_W       = 32,
  parameter int            CNT_W        = 10,
  parameter logic [CNT_W-1:0] LOW_DEFAULT  = 8,
  parameter logic [CNT_W-1:0] HIGH_DEFAULT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);
  logic             enable, ack_en, wait9;
  logic [CNT_W-1:0] low_w, high_w;
  logic [7:0]       tx_byte, rx_byte;
  logic             pend_start, pend_stop, pend_tx, pend_rel;
  logic             take_start, take_stop, take_tx, take_rel;
  logic             ack_seen, busy, stop_seen;

  i2c_bm_regs #(
    .DW      (DATA_W),
    .CW      (CNT_W),
    .LOW_RST (LOW_DEFAULT),
    .HIGH_RST(HIGH_DEFAULT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (reg_en),
    .bus_we    (reg_we),
    .bus_addr  (reg_addr),
    .bus_wdata (reg_wdata),
    .bus_rdata (reg_rdata),
    .rx_byte   (rx_byte),
    .ack_seen  (ack_seen),
    .busy      (busy),
    .stop_seen (stop_seen),
    .take_start(take_start),
    .take_stop (take_stop),
    .take_tx   (take_tx),
    .take_rel  (take_rel),
    .enable    (enable),
    .ack_en    (ack_en),
    .wait9     (wait9),
    .low_w     (low_w),
    .high_w    (high_w),
    .tx_byte   (tx_byte),
    .pend_start(pend_start),
    .pend_stop (pend_stop),
    .pend_tx   (pend_tx),
    .pend_rel  (pend_rel)
  );

  i2c_bm_engine #(.CW(CNT_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .ack_en    (ack_en),
    .wait9     (wait9),
    .low_w     (low_w),
    .high_w    (high_w),
    .tx_byte   (tx_byte),
    .pend_start(pend_start),
    .pend_stop (pend_stop),
    .pend_tx   (pend_tx),
    .pend_rel  (pend_rel),
    .sda_in    (sda_in),
    .take_start(take_start),
    .take_stop (take_stop),
    .take_tx   (take_tx),
    .take_rel  (take_rel),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq),
    .rx_byte   (rx_byte),
    .ack_seen  (ack_seen),
    .busy      (busy),
    .stop_seen (stop_seen)
  );
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe, irq;
  logic        s_low = 1'b0;
  logic        scl_line, sda_line;

  always #5 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_low);

  i2c_byte_master u0 (
    .clk      (clk),
    .rst      (rst),
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .sda_in   (sda_line),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .irq      (irq)
  );

  int checks = 0;
  int errors = 0;

  // bus model state
  int         starts = 0, stops = 0, rises = 0, falls = 0;
  int         irq_cnt = 0, irq_bad = 0;
  int         bitcnt = 0, byte_no = 0;
  int         hi_len = 0, lo_len = 0, last_hi = 0, last_lo = 0;
  bit         rd_dir = 0, nacked = 0, slave_nack = 0;
  bit         p_scl = 1, p_sda = 1, p_irq = 0;
  logic [7:0] rxb = '0, cur_tx = '0;
  logic [7:0] seen_q[$];
  bit         mack_q[$];
  logic [7:0] s_txq[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (irq) irq_cnt++;
      if (irq && p_irq) irq_bad++;
      if (p_scl && scl_line && p_sda && !sda_line) begin
        starts++; bitcnt = 0; byte_no = 0; nacked = 0; rd_dir = 0; s_low = 0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        stops++; s_low = 0;
      end
      if (scl_line) hi_len++; else lo_len++;
      if (!p_scl && scl_line) begin
        rises++; last_lo = lo_len; lo_len = 0;
        if (bitcnt < 8) begin
          rxb = {rxb[6:0], sda_line};
          if (bitcnt == 7) begin
            if (byte_no == 0) rd_dir = sda_line;
            seen_q.push_back(rxb);
          end
        end else if (bitcnt == 8) begin
          if (rd_dir && byte_no > 0) begin
            mack_q.push_back(!sda_line);
            if (sda_line) nacked = 1;
          end
          byte_no++;
        end
        bitcnt++;
      end
      if (p_scl && !scl_line) begin
        falls++; last_hi = hi_len; hi_len = 0;
        if (bitcnt >= 9) bitcnt = 0;
        if (bitcnt < 8) begin
          if (rd_dir && byte_no > 0 && !nacked) begin
            if (bitcnt == 0 && s_txq.size() > 0) cur_tx = s_txq.pop_front();
            s_low = ~cur_tx[7-bitcnt];
          end else s_low = 0;
        end else if (bitcnt == 8) begin
          s_low = (rd_dir && byte_no > 0) ? 1'b0 : ~slave_nack;
        end
      end
      p_scl = scl_line; p_sda = sda_line; p_irq = irq;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int n0, input string req);
    int t = 0;
    while (irq_cnt == n0 && t < 3000) begin
      @(negedge clk); t++;
    end
    chk({req, " irq arrives"}, int'(irq_cnt > n0), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n0, r0, f0;
    repeat (5) @(negedge clk);
    rst = 0;
    idle(2);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
    rd(6'h10, d); chk("R1 status", d, 0);
    // R2 widths read back
    wr(6'h24, 6); wr(6'h28, 5);
    rd(6'h24, d); chk("R2 low width", d, 6);
    rd(6'h28, d); chk("R2 high width", d, 5);
    // R3 triggers ignored while disabled
    wr(6'h0C, 32'h2); wr(6'h00, 32'hFF); idle(40);
    chk("R3 no start", starts, 0);
    chk("R3 lines free", int'(scl_oe | sda_oe), 0);
    rd(6'h10, d); chk("R3 status off", d, 0);
    // R4 start
    wr(6'h08, 32'h83);
    wr(6'h0C, 32'h2); idle(30);
    chk("R4 start seen", starts, 1);
    chk("R4 scl held", scl_oe, 1);
    rd(6'h10, d); chk("R4 busy, no stop", d & 32'h150, 32'h040);
    // R7 held without activity
    f0 = falls; r0 = rises; idle(60);
    chk("R7 no pulses", rises - r0, 0);
    chk("R7 scl low", scl_line, 0);
    // R5/R6 transmit with ACK
    n0 = irq_cnt; wr(6'h00, 32'hA4); wait_irq(n0, "R6");
    chk("R5 byte on bus", seen_q[$], 8'hA4);
    rd(6'h10, d); chk("R6 ack flag", d[8], 1);
    chk("R2 scl high cycles", last_hi, 5);
    chk("R2 scl low cycles", last_lo, 6);
    n0 = irq_cnt; wr(6'h00, 32'h3C); wait_irq(n0, "R5");
    chk("R5 second byte", seen_q[$], 8'h3C);
    // R6 slave refuses
    slave_nack = 1;
    n0 = irq_cnt; wr(6'h00, 32'h5A); wait_irq(n0, "R6");
    chk("R5 third byte", seen_q[$], 8'h5A);
    rd(6'h10, d); chk("R6 nack flag", d[8], 0);
    slave_nack = 0;
    // R11 stop
    wr(6'h0C, 32'h1); idle(30);
    chk("R11 stop seen on bus", stops, 1);
    rd(6'h10, d); chk("R11 stop flag, not busy", d & 32'h050, 32'h010);
    chk("R1 idle lines", int'(scl_oe | sda_oe), 0);
    // read transfer, wait after 8th clock
    s_txq.push_back(8'h96); s_txq.push_back(8'h4B);
    wr(6'h0C, 32'h2); idle(30);
    rd(6'h10, d); chk("R4 stop flag cleared", d & 32'h050, 32'h040);
    wr(6'h08, 32'h81);
    n0 = irq_cnt; wr(6'h00, 32'hA5); wait_irq(n0, "R6");
    rd(6'h10, d); chk("R6 address ack", d[8], 1);
    r0 = rises; n0 = irq_cnt; wr(6'h0C, 32'h4); wait_irq(n0, "R8");
    idle(40);
    chk("R8 eight clocks", rises - r0, 8);
    rd(6'h00, d); chk("R8 first rx byte", d, 32'h96);
    r0 = rises; n0 = irq_cnt; wr(6'h0C, 32'h4); wait_irq(n0, "R8");
    idle(10);
    chk("R8 ninth plus eight", rises - r0, 9);
    chk("R9 master ack", int'(mack_q[$]), 1);
    rd(6'h00, d); chk("R8 second rx byte", d, 32'h4B);
    // R10 last byte: ninth clock, NACK
    wr(6'h08, 32'h82);
    r0 = rises; n0 = irq_cnt; wr(6'h0C, 32'h4); wait_irq(n0, "R10");
    idle(10);
    chk("R10 one clock then wait", rises - r0, 1);
    chk("R9 master nack", int'(mack_q[$]), 0);
    chk("R9 ack count", mack_q.size(), 2);
    // R12 repeated start
    wr(6'h08, 32'h83);
    wr(6'h0C, 32'h2); idle(40);
    chk("R12 second start", starts, 3);
    chk("R12 no stop between", stops, 1);
    n0 = irq_cnt; wr(6'h00, 32'h11); wait_irq(n0, "R12");
    chk("R12 byte after restart", seen_q[$], 8'h11);
    // R3 disable mid-transfer
    wr(6'h08, 32'h0); idle(5);
    chk("R3 lines released", int'(scl_oe | sda_oe), 0);
    rd(6'h10, d); chk("R3 busy/stop cleared", d & 32'h050, 0);
    wr(6'h0C, 32'h1); idle(30);
    chk("R3 stop ignored", stops, 1);
    // R13 single pulses, one per wait
    chk("R13 irq count", irq_cnt, 8);
    chk("R13 single-cycle", irq_bad, 0);
    finish_run();
  end
endmodule